// File: doc/BRIEF.md
# I2C Slave with Busy and Read-Request Flow Control

This block is an I2C target for a serial control port that is always run by an external host. It never generates SCL and never starts a transaction. It watches the bus, recognises START and STOP conditions, and matches its own 7-bit address (default 0x40, so 0x80 addresses a write and 0x81 a read). Bytes are 8 bits wide and travel most significant bit first. Received bytes go to the chip's internal logic on a valid/ready byte stream. Bytes for the host come from a second valid/ready stream.

Two active-low outputs tell the host how the internal side is doing. `busyN` goes low while the receive side cannot take bytes. A byte that the host writes during that time is refused with a NACK and is lost. `irqN` goes low while the transmit side holds data, which asks the host to start a read. When `strictEn` is set, the block also stretches the clock: it holds SCL low at a byte boundary until the internal side can take or supply the byte. `busyN` still works in that case. Both bus lines are open-drain; each output enable pulls its line low.

Top module: `i2c_flow_slave`

## Requirements
- R1: The address byte is acknowledged (SDA pulled low during the ninth clock) only when its upper 7 bits equal the slave address (0x40: byte 0x80 = write, 0x81 = read). Any other address is NACKed, and the block neither drives SDA nor delivers data until the next START.
- R2: In a write, each received byte (MSB first) appears on `rxData` with `rxValid` high for exactly one clock while `rxReady` is high, and the byte is ACKed.
- R3: `busyN` is low one clock after `rxReady` is low and high one clock after `rxReady` is high.
- R4: With `strictEn` low and `rxReady` low, a written byte is NACKed and discarded: `rxValid` stays low and SCL is never held.
- R5: `irqN` is low one clock after `txValid` is high and returns high once the transmit stream is empty.
- R6: In a read, each byte is taken from the transmit stream with a one-clock `txReady` pulse and shifted out MSB first. A further byte is taken only after the host ACKs. After a host NACK, SDA is released and no further byte is taken.
- R7: With `strictEn` low and no transmit data, a read returns 0xFF (SDA left released) and `txReady` stays low.
- R8: With `strictEn` high and `rxReady` low, SCL is held low after the eighth data bit of a written byte, with `busyN` low. When `rxReady` rises, the byte is delivered and the ACK is set up, and SCL is released two clocks after the rise.
- R9: With `strictEn` high and no transmit data, SCL is held low at the start of a read byte while `irqN` stays high. SCL is released two clocks after `txValid` rises, and that byte is the one sent.
- R10: A STOP in the middle of a byte abandons the transaction, with no byte delivered. A repeated START begins a new address phase.
- R11: In reset, `sclOe`, `sdaOe`, `rxValid` and `txReady` are low, and `busyN` and `irqN` are high.
- R12: `sclOe` is asserted only while `strictEn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strictEn | input | 1 | Enables clock stretching |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pulls SCL low when high |
| sdaOe | output | 1 | Pulls SDA low when high |
| rxData | output | 8 | Byte received from the host |
| rxValid | output | 1 | rxData is valid this cycle |
| rxReady | input | 1 | Internal side can take a byte |
| txData | input | 8 | Byte to send to the host |
| txValid | input | 1 | txData holds a byte to send |
| txReady | output | 1 | txData is consumed this cycle |
| busyN | output | 1 | Active-low busy flag to the host |
| irqN | output | 1 | Active-low read request to the host |

## Verification
The bench acts as a bus master on an open-drain model that honours clock stretching.

- **Address matching.** The bench drives a foreign address. A design with a loose address compare would ACK it and then accept the following write.
- **Refused writes.** The bench writes while the receive side is not ready in non-strict mode. The byte must be NACKed with no `rxValid`; a design that ignored `rxReady` would deliver it.
- **Read prefetch.** The bench ends a read with a NACK. A design that fetched ahead would consume an extra transmit byte, which shows as one extra `txReady` pulse.
- **Stretch release.** In both stretch cases the bench counts the clocks from the ready or valid edge to the release of SCL.
- **Abandoned bytes.** A STOP after four data bits must deliver nothing. A design that kept a stale bit count would then misalign the next write.

// File: rtl/i2c_flow_pkg.sv
package i2c_flow_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_WAIT,
    ST_WR_REL,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_WAIT,
    ST_RD_REL,
    ST_RD_ACK
  } i2cState_t;

  // control -> datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadOnes;
    logic clrCnt;
    logic ackOn;
    logic ackOff;
    logic rdOn;
    logic rdOff;
    logic sclHold;
    logic sclRel;
    logic latchAddr;
    logic rxPush;
  } i2cStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
    logic cntFull;
    logic cntLast;
    logic addrHit;
    logic rwBit;
  } i2cStatus_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '1;
        else       pipe[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '1;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_flow_dp.sv
module i2c_flow_dp
  import i2c_flow_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SLAVE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  i2cStrobe_t        stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              rxReady,
  output i2cStatus_t        st,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txReady,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              busyN,
  output logic              irqN
);
  localparam int unsigned ADDR_W = DATA_W - 1;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);

  logic              sclD, sdaD;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              ackLow, rdMode, sclHoldReg, rwReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.loadTx) begin
      shiftReg <= txData;
    end else if (stb.loadOnes) begin
      shiftReg <= '1;
    end else if (stb.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
    end else if (stb.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          bitCnt <= '0;
    else if (stb.clrCnt)                bitCnt <= '0;
    else if (stb.shiftIn || stb.shiftOut) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackLow     <= 1'b0;
      rdMode     <= 1'b0;
      sclHoldReg <= 1'b0;
      rwReg      <= 1'b0;
      busyN      <= 1'b1;
      irqN       <= 1'b1;
    end else begin
      if (stb.ackOn)          ackLow <= 1'b1;
      else if (stb.ackOff)    ackLow <= 1'b0;
      if (stb.rdOn)           rdMode <= 1'b1;
      else if (stb.rdOff)     rdMode <= 1'b0;
      if (stb.sclHold)        sclHoldReg <= 1'b1;
      else if (stb.sclRel)    sclHoldReg <= 1'b0;
      if (stb.latchAddr)      rwReg <= shiftReg[0];
      busyN <= rxReady;
      irqN  <= !txValid;
    end
  end

  always_comb begin
    st.startEv = sclS && sclD && sdaD && !sdaS;
    st.stopEv  = sclS && sclD && !sdaD && sdaS;
    st.sclRise = sclS && !sclD;
    st.sclFall = !sclS && sclD;
    st.sdaBit  = sdaS;
    st.cntFull = (bitCnt == CNT_W'(DATA_W));
    st.cntLast = (bitCnt == CNT_W'(DATA_W - 1));
    st.addrHit = (shiftReg[DATA_W-1:1] == ADDR_W'(SLAVE_ADDR));
    st.rwBit   = rwReg;
  end

  assign rxData  = shiftReg;
  assign rxValid = stb.rxPush;
  assign txReady = stb.loadTx;
  assign sdaOe   = ackLow || (rdMode && !shiftReg[DATA_W-1]);
  assign sclOe   = sclHoldReg;
endmodule

// File: rtl/i2c_flow_ctrl.sv
module i2c_flow_ctrl
  import i2c_flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strictEn,
  input  logic       rxReady,
  input  logic       txValid,
  input  i2cStatus_t st,
  output i2cStrobe_t stb
);
  i2cState_t state, nextState;
  logic      mAck, nextAck, doFetch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      mAck  <= 1'b0;
    end else begin
      state <= nextState;
      mAck  <= nextAck;
    end
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    nextAck   = mAck;
    doFetch   = 1'b0;
    if (st.stopEv) begin
      nextState  = ST_IDLE;
      stb.ackOff = 1'b1;
      stb.rdOff  = 1'b1;
      stb.sclRel = 1'b1;
    end else if (st.startEv) begin
      nextState  = ST_ADDR;
      stb.clrCnt = 1'b1;
      stb.ackOff = 1'b1;
      stb.rdOff  = 1'b1;
      stb.sclRel = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (st.sclRise) stb.shiftIn = 1'b1;
          else if (st.sclFall && st.cntFull) begin
            stb.latchAddr = 1'b1;
            if (st.addrHit) begin
              stb.ackOn = 1'b1;
              nextState = ST_ADDR_ACK;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (st.sclFall) begin
            stb.ackOff = 1'b1;
            if (st.rwBit) begin
              doFetch = 1'b1;
            end else begin
              stb.clrCnt = 1'b1;
              nextState  = ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: begin
          if (st.sclRise) stb.shiftIn = 1'b1;
          else if (st.sclFall && st.cntFull) begin
            if (rxReady) begin
              stb.rxPush = 1'b1;
              stb.ackOn  = 1'b1;
              nextState  = ST_WR_ACK;
            end else if (strictEn) begin
              stb.sclHold = 1'b1;
              nextState   = ST_WR_WAIT;
            end else begin
              nextState = ST_WR_ACK;  // refused: SDA stays released
            end
          end
        end
        ST_WR_WAIT: begin
          if (rxReady) begin
            stb.rxPush = 1'b1;
            stb.ackOn  = 1'b1;
            nextState  = ST_WR_REL;
          end
        end
        ST_WR_REL: begin
          stb.sclRel = 1'b1;
          nextState  = ST_WR_ACK;
        end
        ST_WR_ACK: begin
          if (st.sclFall) begin
            stb.ackOff = 1'b1;
            stb.clrCnt = 1'b1;
            nextState  = ST_WR_DATA;
          end
        end
        ST_RD_WAIT: begin
          if (txValid) begin
            stb.loadTx = 1'b1;
            stb.clrCnt = 1'b1;
            stb.rdOn   = 1'b1;
            nextState  = ST_RD_REL;
          end
        end
        ST_RD_REL: begin
          stb.sclRel = 1'b1;
          nextState  = ST_RD_DATA;
        end
        ST_RD_DATA: begin
          if (st.sclFall) begin
            if (st.cntLast) begin
              stb.rdOff = 1'b1;
              nextState = ST_RD_ACK;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (st.sclRise) nextAck = !st.sdaBit;
          else if (st.sclFall) begin
            if (mAck) doFetch = 1'b1;
            else      nextState = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
      if (doFetch) begin
        if (txValid) begin
          stb.loadTx = 1'b1;
          stb.clrCnt = 1'b1;
          stb.rdOn   = 1'b1;
          nextState  = ST_RD_DATA;
        end else if (strictEn) begin
          stb.sclHold = 1'b1;
          nextState   = ST_RD_WAIT;
        end else begin
          stb.loadOnes = 1'b1;
          stb.clrCnt   = 1'b1;
          stb.rdOn     = 1'b1;
          nextState    = ST_RD_DATA;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_flow_slave.sv
module i2c_flow_slave
  import i2c_flow_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SLAVE_ADDR  = 'h40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strictEn,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              busyN,
  output logic              irqN
);
  logic [1:0] syncOut;
  i2cStrobe_t stb;
  i2cStatus_t st;

  i2c_bus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(syncOut)
  );

  i2c_flow_dp #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclS(syncOut[1]), .sdaS(syncOut[0]),
    .stb(stb), .txData(txData), .txValid(txValid), .rxReady(rxReady),
    .st(st), .rxData(rxData), .rxValid(rxValid), .txReady(txReady),
    .sdaOe(sdaOe), .sclOe(sclOe), .busyN(busyN), .irqN(irqN)
  );

  i2c_flow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strictEn(strictEn), .rxReady(rxReady),
    .txValid(txValid), .st(st), .stb(stb)
  );
endmodule

// File: rtl/i2c_flow_check.sv
module i2c_flow_check (
  input logic clk,
  input logic rstN,
  input logic strictEn,
  input logic sclOe,
  input logic rxValid,
  input logic rxReady,
  input logic txValid,
  input logic txReady,
  input logic busyN,
  input logic irqN
);
  assert_rx_accepted_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> rxReady);
  assert_rx_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_busy_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rxReady |=> !busyN);
  assert_busy_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |=> busyN);
  assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !irqN);
  assert_tx_offered_R6: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txValid);
  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && !rxReady && !txValid) |=> sclOe);
  assert_stretch_strict_R12: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> strictEn);
endmodule

bind i2c_flow_slave i2c_flow_check u_check (.*);

// File: tb/i2c_flow_slave_bench.sv
module i2c_flow_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strictEn = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclOe, sdaOe, rxValid, txReady, busyN, irqN, txValid;
  logic rxReady = 1'b1;
  logic [7:0] rxData, txData;
  logic sclLine, sdaLine;

  int total = 0, bad = 0;
  logic [7:0] txMem [16];
  logic [7:0] rxLog [32];
  int txHead = 0, txTail = 0, rxCnt = 0, holdCnt = 0, sdaCnt = 0;

  always #4 clk = ~clk;

  assign sclLine = !(mSclLow || sclOe);
  assign sdaLine = !(mSdaLow || sdaOe);
  assign txValid = (txHead < txTail);
  assign txData  = txMem[txHead[3:0]];

  i2c_flow_slave u_i2c_flow_slave (
    .clk(clk), .rstN(rstN), .strictEn(strictEn), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady), .busyN(busyN), .irqN(irqN)
  );

  always @(posedge clk) begin
    if (txValid && txReady) txHead <= txHead + 1;
    if (rxValid && rxReady) begin
      rxLog[rxCnt[4:0]] <= rxData;
      rxCnt <= rxCnt + 1;
    end
    if (sclOe) holdCnt <= holdCnt + 1;
    if (sdaOe) sdaCnt <= sdaCnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sclPulse(output logic smp);
    mSclLow = 1'b0;
    while (!sclLine) tick(1);
    tick(Q);
    smp = sdaLine;
    tick(Q);
    mSclLow = 1'b1;
    tick(Q);
  endtask

  task automatic sendBit(input logic b);
    logic d;
    mSdaLow = !b;
    tick(Q);
    sclPulse(d);
  endtask

  task automatic recvBit(output logic b);
    mSdaLow = 1'b0;
    tick(Q);
    sclPulse(b);
  endtask

  task automatic startCond();
    mSdaLow = 1'b0;
    tick(Q);
    mSclLow = 1'b0;
    while (!sclLine) tick(1);
    tick(Q);
    mSdaLow = 1'b1;
    tick(Q);
    mSclLow = 1'b1;
    tick(Q);
  endtask

  task automatic stopCond();
    mSdaLow = 1'b1;
    tick(Q);
    mSclLow = 1'b0;
    while (!sclLine) tick(1);
    tick(Q);
    mSdaLow = 1'b0;
    tick(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(a);
    acked = !a;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
    sendBit(!giveAck);
  endtask

  task automatic pushTx(input logic [7:0] v);
    txMem[txTail[3:0]] = v;
    txTail++;
  endtask

  task automatic testReset();
    check(sclOe == 0 && sdaOe == 0, "R11", "bus enables in reset", {sclOe, sdaOe}, 0);
    check(rxValid == 0 && txReady == 0, "R11", "strobes in reset", {rxValid, txReady}, 0);
    check(busyN == 1 && irqN == 1, "R11", "flags in reset", {busyN, irqN}, 3);
  endtask

  task automatic testWrite();
    logic ack;
    int base = rxCnt;
    startCond();
    sendByte(8'h80, ack);
    check(ack, "R1", "write address ack", ack, 1);
    sendByte(8'hA5, ack);
    check(ack, "R2", "data ack 1", ack, 1);
    sendByte(8'h3C, ack);
    check(ack, "R2", "data ack 2", ack, 1);
    stopCond();
    check(rxCnt - base == 2, "R2", "bytes delivered", rxCnt - base, 2);
    check(rxLog[base[4:0]] == 8'hA5, "R2", "byte 0", rxLog[base[4:0]], 8'hA5);
    check(rxLog[base[4:0] + 5'd1] == 8'h3C, "R2", "byte 1", rxLog[base[4:0] + 5'd1], 8'h3C);
  endtask

  task automatic testBadAddr();
    logic ack;
    int base = rxCnt;
    int sdaBase;
    startCond();
    sdaBase = sdaCnt;
    sendByte(8'h90, ack);
    check(!ack, "R1", "foreign address nack", ack, 0);
    sendByte(8'h00, ack);
    check(!ack, "R1", "byte after foreign address", ack, 0);
    stopCond();
    check(sdaCnt == sdaBase, "R1", "sda untouched", sdaCnt - sdaBase, 0);
    check(rxCnt == base, "R1", "nothing delivered", rxCnt - base, 0);
  endtask

  task automatic testBusy();
    logic ack;
    int base = rxCnt;
    int hBase = holdCnt;
    rxReady = 1'b0;
    tick(2);
    check(busyN == 0, "R3", "busy low", busyN, 0);
    startCond();
    sendByte(8'h80, ack);
    check(ack, "R1", "address ack while busy", ack, 1);
    sendByte(8'h77, ack);
    check(!ack, "R4", "refused byte nack", ack, 0);
    stopCond();
    check(rxCnt == base, "R4", "refused byte dropped", rxCnt - base, 0);
    check(holdCnt == hBase, "R12", "no hold in non-strict", holdCnt - hBase, 0);
    rxReady = 1'b1;
    tick(2);
    check(busyN == 1, "R3", "busy released", busyN, 1);
  endtask

  task automatic testRead();
    logic ack;
    logic [7:0] v;
    int h0 = txHead;
    pushTx(8'hC3); pushTx(8'h5A); pushTx(8'h99);
    tick(2);
    check(irqN == 0, "R5", "irq low with data", irqN, 0);
    startCond();
    sendByte(8'h81, ack);
    check(ack, "R1", "read address ack", ack, 1);
    recvByte(1'b1, v);
    check(v == 8'hC3, "R6", "read byte 0", v, 8'hC3);
    recvByte(1'b0, v);
    check(v == 8'h5A, "R6", "read byte 1", v, 8'h5A);
    tick(4);
    check(txHead - h0 == 2, "R6", "no fetch after nack", txHead - h0, 2);
    check(sdaOe == 0, "R6", "sda released after nack", sdaOe, 0);
    stopCond();
    check(irqN == 0, "R5", "irq held with one left", irqN, 0);
    startCond();
    sendByte(8'h81, ack);
    recvByte(1'b0, v);
    stopCond();
    check(v == 8'h99, "R6", "read byte 2", v, 8'h99);
    tick(2);
    check(irqN == 1, "R5", "irq high when empty", irqN, 1);
  endtask

  task automatic testEmptyRead();
    logic ack;
    logic [7:0] v;
    int h0 = txHead;
    int hBase = holdCnt;
    startCond();
    sendByte(8'h81, ack);
    recvByte(1'b0, v);
    stopCond();
    check(v == 8'hFF, "R7", "empty read value", v, 8'hFF);
    check(txHead == h0, "R7", "no txReady", txHead - h0, 0);
    check(holdCnt == hBase, "R12", "no hold on empty read", holdCnt - hBase, 0);
  endtask

  task automatic testStrictWrite();
    logic ack;
    int base = rxCnt;
    strictEn = 1'b1;
    rxReady = 1'b0;
    startCond();
    sendByte(8'h80, ack);
    fork
      sendByte(8'h4E, ack);
      begin
        while (!sclOe) tick(1);
        tick(40);
        check(sclLine == 0, "R8", "scl held", sclLine, 0);
        check(busyN == 0, "R8", "busy during hold", busyN, 0);
        check(rxCnt == base, "R8", "not delivered during hold", rxCnt - base, 0);
        rxReady = 1'b1;
        tick(1);
        check(sclOe == 1, "R8", "hold one clock after ready", sclOe, 1);
        tick(1);
        check(sclOe == 0, "R8", "released two clocks after ready", sclOe, 0);
      end
    join
    check(ack, "R8", "stretched byte ack", ack, 1);
    stopCond();
    check(rxCnt - base == 1 && rxLog[base[4:0]] == 8'h4E, "R8", "stretched byte",
          rxLog[base[4:0]], 8'h4E);
    strictEn = 1'b0;
  endtask

  task automatic testStrictRead();
    logic ack;
    logic [7:0] v;
    strictEn = 1'b1;
    fork
      begin
        startCond();
        sendByte(8'h81, ack);
        recvByte(1'b0, v);
      end
      begin
        while (!sclOe) tick(1);
        tick(40);
        check(sclLine == 0, "R9", "scl held on read", sclLine, 0);
        check(irqN == 1, "R9", "irq high while empty", irqN, 1);
        pushTx(8'hB7);
        tick(1);
        check(sclOe == 1, "R9", "hold one clock after valid", sclOe, 1);
        tick(1);
        check(sclOe == 0, "R9", "released two clocks after valid", sclOe, 0);
      end
    join
    stopCond();
    check(v == 8'hB7, "R9", "stretched read value", v, 8'hB7);
    strictEn = 1'b0;
  endtask

  task automatic testRestart();
    logic ack;
    logic [7:0] v;
    int base = rxCnt;
    pushTx(8'h6D);
    startCond();
    sendByte(8'h80, ack);
    sendByte(8'h11, ack);
    startCond();
    sendByte(8'h81, ack);
    check(ack, "R10", "address ack after repeated start", ack, 1);
    recvByte(1'b0, v);
    stopCond();
    check(v == 8'h6D, "R10", "read after repeated start", v, 8'h6D);
    check(rxCnt - base == 1 && rxLog[base[4:0]] == 8'h11, "R10", "write before restart",
          rxLog[base[4:0]], 8'h11);
  endtask

  task automatic testStopMid();
    logic ack;
    int base = rxCnt;
    startCond();
    sendByte(8'h80, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    stopCond();
    check(rxCnt == base, "R10", "partial byte dropped", rxCnt - base, 0);
    startCond();
    sendByte(8'h80, ack);
    sendByte(8'h22, ack);
    stopCond();
    check(rxCnt - base == 1 && rxLog[base[4:0]] == 8'h22, "R10", "clean byte after stop",
          rxLog[base[4:0]], 8'h22);
  endtask

  initial begin
    tick(5);
    testReset();
    rstN = 1'b1;
    tick(5);
    testWrite();
    testBadAddr();
    testBusy();
    testRead();
    testEmptyRead();
    testStrictWrite();
    testStrictRead();
    testRestart();
    testStopMid();
    tick(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule